// File: doc/BRIEF.md
# USB Root-Hub Port Status and Control Register

This block holds the per-port status and control bits of one USB 2.0 root-hub port. Two sides update it. Software writes a whole register word, and each bit follows its own rule: read/write, read-only or write-one-to-clear. Hardware raises event inputs. These are a port error found at the end-of-frame check point, the overcurrent level, a J-to-K transition on the lines, an acknowledge that the port has really entered suspend, and a signal that the port has reached high-speed idle after resume.

The block decodes the port state (disabled, enabled, suspended) from its enable and suspend bits. It drives resume signalling while the force-resume bit is set. It also raises a one-cycle port-change pulse toward the global status register, but only when hardware starts a resume from the lines. A resume that software starts raises no such pulse. Suspend and resume follow a handshake. A suspend request becomes visible only after the acknowledge arrives. Clearing force-resume drops suspend at once, while the force-resume bit itself holds until the line reaches high-speed idle.

Register layout (REG_W bits, other bits read 0): bit 0 enable, bit 1 enable-change, bit 2 overcurrent-active, bit 3 overcurrent-change, bit 6 force-resume, bit 7 suspend.

Top module: `usb_portsc`

## Requirements
- R1: After reset every register bit reads 0, the port state is disabled (2'b00), and resume drive and the change pulse are 0.
- R2: port_state is 2'b00 when enable (bit 0) is 0, 2'b01 when enable is 1 and suspend (bit 7) is 0, and 2'b10 when both are 1.
- R3: Writing 1 to suspend on an enabled port only registers a request, and bit 7 reads 1 from the cycle after susp_ack. Writing 0 to suspend has no effect. A suspend request made while the port is disabled is dropped and a later susp_ack does not set the bit.
- R4: A software write of 0 to force-resume (bit 6) while it reads 1 clears suspend in the next cycle.
- R5: A jk_det pulse while the port is suspended and force-resume is 0 sets force-resume and gives a one-cycle chg_pulse in the next cycle. jk_det in any other state changes nothing.
- R6: Software writing 1 to force-resume on an enabled port sets the bit without a chg_pulse.
- R7: rsm_drive is 1 exactly while force-resume reads 1.
- R8: After software writes 0 to force-resume, the bit keeps reading 1 until hs_idle. It reads 0 from the cycle after hs_idle.
- R9: Overcurrent-active (bit 2) follows oc_in with one cycle of delay. Any difference between them sets overcurrent-change (bit 3).
- R10: Enable-change (bit 1) and overcurrent-change are cleared by writing 1 to them. A set and a clear in the same cycle leave the bit at 1.
- R11: An eof_err pulse while enabled clears enable and sets enable-change. eof_err while disabled and a software enable never set enable-change. An error beats a software write of enable=1 in the same cycle.
- R12: Whenever the port becomes disabled, suspend, any pending suspend request and force-resume are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software register write strobe |
| wr_data | input | REG_W | Software write word |
| rd_data | output | REG_W | Current register contents |
| eof_err | input | 1 | Port error found at the end-of-frame check point |
| oc_in | input | 1 | Overcurrent level from the port power switch |
| jk_det | input | 1 | J-to-K transition seen on the lines |
| susp_ack | input | 1 | Port has entered suspend |
| hs_idle | input | 1 | Port has reached high-speed idle after resume |
| port_state | output | 2 | 00 disabled, 01 enabled, 10 suspended |
| rsm_drive | output | 1 | Drive resume signalling |
| chg_pulse | output | 1 | One-cycle port-change pulse to the global status |

## Verification
The main collision is a hardware set of a change bit and the software write-one-to-clear of the same bit in the same cycle. The bench provokes it twice. It toggles oc_in in the cycle of a write that clears overcurrent-change, and it raises eof_err in the cycle of a write that clears enable-change. Both times the bit must read 1 afterwards, and in the second case enable must read 0 despite the write of 1. The bench also checks that a software resume on a suspended port never pulses chg_pulse while a line resume does.

// File: rtl/usb_portsc_pkg.sv
package usb_portsc_pkg;

    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_PEC   = 1;
    localparam int unsigned BIT_OCA   = 2;
    localparam int unsigned BIT_OCC   = 3;
    localparam int unsigned BIT_FPR   = 6;
    localparam int unsigned BIT_SUSP  = 7;
    localparam int unsigned MIN_REG_W = 8;

    typedef enum logic [1:0] {
        PS_DIS  = 2'b00,
        PS_EN   = 2'b01,
        PS_SUSP = 2'b10
    } port_state_e;

    typedef struct packed {
        logic en;
        logic susp;
        logic susp_req;
        logic fpr;
        logic fpr_exit;
        logic chg;
    } link_st_t;

endpackage

// File: rtl/usb_portsc_chg.sv
module usb_portsc_chg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;

    // R10: a hardware set wins over a same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R10: a lone write-one clears the flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/usb_portsc_link.sv
module usb_portsc_link
    import usb_portsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_en_bit,
    input  logic wr_susp_bit,
    input  logic wr_fpr_bit,
    input  logic eof_err,
    input  logic jk_det,
    input  logic susp_ack,
    input  logic hs_idle,
    output logic en_o,
    output logic susp_o,
    output logic fpr_o,
    output logic chg_o,
    output logic err_dis_o
);

    link_st_t st_d, st_q;
    logic     jk_hit;
    logic     err_dis;
    logic     sw_dis;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        jk_hit   = jk_det && st_q.en && st_q.susp && !st_q.fpr;
        err_dis  = eof_err && st_q.en;
        sw_dis   = wr_en && !wr_en_bit;

        // suspend becomes visible only on acknowledge
        if (susp_ack && st_q.susp_req && st_q.en) begin
            st_d.susp     = 1'b1;
            st_d.susp_req = 1'b0;
        end

        // line-initiated resume
        if (jk_hit) begin
            st_d.fpr = 1'b1;
            st_d.chg = 1'b1;
        end

        if (wr_en) begin
            st_d.en = wr_en_bit;
            if (wr_susp_bit && st_q.en && !st_q.susp && !st_q.fpr)
                st_d.susp_req = 1'b1;
            if (wr_fpr_bit && st_q.en && !st_q.fpr)
                st_d.fpr = 1'b1;
            if (!wr_fpr_bit && st_q.fpr && !st_q.fpr_exit) begin
                st_d.fpr_exit = 1'b1;
                st_d.susp     = 1'b0;
                st_d.susp_req = 1'b0;
            end
        end

        // resume finishes when the line reaches high-speed idle
        if (hs_idle && st_q.fpr_exit) begin
            st_d.fpr      = 1'b0;
            st_d.fpr_exit = 1'b0;
        end

        if (err_dis) st_d.en = 1'b0;

        if (!st_d.en) begin
            st_d.susp     = 1'b0;
            st_d.susp_req = 1'b0;
            st_d.fpr      = 1'b0;
            st_d.fpr_exit = 1'b0;
            st_d.chg      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o      = st_q.en;
    assign susp_o    = st_q.susp;
    assign fpr_o     = st_q.fpr;
    assign chg_o     = st_q.chg;
    assign err_dis_o = err_dis;

    // R3: suspend only rises after an acknowledge
    p_susp_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_o) |-> $past(susp_ack));

    // R4: software ending a resume drops suspend
    p_resume_drops_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_fpr_bit && fpr_o) |=> !susp_o);

    // R5: line resume on a suspended port sets the bit and pulses
    p_line_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jk_det && en_o && susp_o && !fpr_o && !eof_err && !sw_dis)
        |=> (fpr_o && chg_o));

    // R6: the change pulse never comes from a software write
    p_no_sw_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> $past(jk_det));

    // R8: force-resume only falls on idle or a disable
    p_fpr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fpr_o) |-> ($past(hs_idle) || $past(eof_err)
                          || ($past(wr_en) && !$past(wr_en_bit))));

endmodule

// File: rtl/usb_portsc.sv
module usb_portsc
    import usb_portsc_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             eof_err,
    input  logic             oc_in,
    input  logic             jk_det,
    input  logic             susp_ack,
    input  logic             hs_idle,
    output logic [1:0]       port_state,
    output logic             rsm_drive,
    output logic             chg_pulse
);

    localparam int unsigned NCHG    = 2;
    localparam int unsigned CHG_PEC = 0;
    localparam int unsigned CHG_OCC = 1;

    typedef struct packed {
        logic oca;
    } top_st_t;

    top_st_t         st_d, st_q;
    logic            en, susp, fpr, err_dis;
    logic [NCHG-1:0] chg_set, chg_clr, chg_q;
    logic            unused_wr;

    assign unused_wr = ^wr_data;

    usb_portsc_link i_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_en_bit  (wr_data[BIT_EN]),
        .wr_susp_bit(wr_data[BIT_SUSP]),
        .wr_fpr_bit (wr_data[BIT_FPR]),
        .eof_err    (eof_err),
        .jk_det     (jk_det),
        .susp_ack   (susp_ack),
        .hs_idle    (hs_idle),
        .en_o       (en),
        .susp_o     (susp),
        .fpr_o      (fpr),
        .chg_o      (chg_pulse),
        .err_dis_o  (err_dis)
    );

    always_comb begin
        st_d     = st_q;
        st_d.oca = oc_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        chg_set          = '0;
        chg_clr          = '0;
        chg_set[CHG_PEC] = err_dis;
        chg_set[CHG_OCC] = oc_in ^ st_q.oca;
        chg_clr[CHG_PEC] = wr_en && wr_data[BIT_PEC];
        chg_clr[CHG_OCC] = wr_en && wr_data[BIT_OCC];
    end

    for (genvar gi = 0; gi < NCHG; gi++) begin : g_chg
        usb_portsc_chg i_chg (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(chg_set[gi]),
            .clr_i(chg_clr[gi]),
            .q_o  (chg_q[gi])
        );
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_EN]   = en;
        rd_data[BIT_PEC]  = chg_q[CHG_PEC];
        rd_data[BIT_OCA]  = st_q.oca;
        rd_data[BIT_OCC]  = chg_q[CHG_OCC];
        rd_data[BIT_FPR]  = fpr;
        rd_data[BIT_SUSP] = susp;
    end

    always_comb begin
        if (!en)       port_state = PS_DIS;
        else if (susp) port_state = PS_SUSP;
        else           port_state = PS_EN;
    end

    assign rsm_drive = fpr;

    // R9: a level difference raises overcurrent-change
    p_oc_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_in != rd_data[BIT_OCA]) |=> rd_data[BIT_OCC]);

    // R11: enable-change only rises after an error on a live port
    p_pec_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[BIT_PEC]) |-> ($past(eof_err) && $past(port_state) != PS_DIS));

    // R7, R12: resume is never driven on a disabled port
    p_rsm_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_drive |-> (port_state != PS_DIS));

    // R2: the suspended state never shows without enable
    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_state != 2'b11);

endmodule

// File: tb/test_usb_portsc.sv
module test_usb_portsc;

    localparam int REG_W = 8;
    localparam logic [7:0] M_EN   = 8'h01;
    localparam logic [7:0] M_PEC  = 8'h02;
    localparam logic [7:0] M_OCC  = 8'h08;
    localparam logic [7:0] M_FPR  = 8'h40;
    localparam logic [7:0] M_SUSP = 8'h80;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             eof_err = 1'b0;
    logic             oc_in = 1'b0;
    logic             jk_det = 1'b0;
    logic             susp_ack = 1'b0;
    logic             hs_idle = 1'b0;
    logic [1:0]       port_state;
    logic             rsm_drive;
    logic             chg_pulse;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    usb_portsc #(.REG_W(REG_W)) i_usb_portsc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eof_err(eof_err), .oc_in(oc_in),
        .jk_det(jk_det), .susp_ack(susp_ack), .hs_idle(hs_idle),
        .port_state(port_state), .rsm_drive(rsm_drive), .chg_pulse(chg_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // 0 jk, 1 ack, 2 idle, 3 error
    task automatic ev(input int which);
        case (which)
            0: jk_det   = 1'b1;
            1: susp_ack = 1'b1;
            2: hs_idle  = 1'b1;
            default: eof_err = 1'b1;
        endcase
        @(negedge clk);
        jk_det = 1'b0; susp_ack = 1'b0; hs_idle = 1'b0; eof_err = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 0);
        chk("R1 state", port_state, 2'b00);
        chk("R1 rsm", rsm_drive, 0);
        chk("R1 chg", chg_pulse, 0);
    endtask

    task automatic t_enable;
        wr(M_EN);
        chg_if_r2: chk("R2 enabled", port_state, 2'b01);
        chk("R11 no pec on enable", rd_data[1], 0);
    endtask

    task automatic t_suspend;
        wr(M_EN | M_SUSP);
        chk("R3 susp before ack", rd_data[7], 0);
        chk("R2 still enabled", port_state, 2'b01);
        idle(2);
        chk("R3 susp waits", rd_data[7], 0);
        ev(1);
        chk("R3 susp after ack", rd_data[7], 1);
        chk("R2 suspended", port_state, 2'b10);
        wr(M_EN);
        chk("R3 write 0 ignored", rd_data[7], 1);
    endtask

    task automatic t_line_resume;
        ev(0);
        chk("R5 fpr set", rd_data[6], 1);
        chk("R5 pulse", chg_pulse, 1);
        chk("R7 rsm on", rsm_drive, 1);
        idle(1);
        chk("R5 pulse one cycle", chg_pulse, 0);
        wr(M_EN);
        chk("R4 susp cleared", rd_data[7], 0);
        chk("R8 fpr held", rd_data[6], 1);
        idle(3);
        chk("R8 fpr still held", rd_data[6], 1);
        chk("R7 rsm held", rsm_drive, 1);
        ev(2);
        chk("R8 fpr cleared", rd_data[6], 0);
        chk("R7 rsm off", rsm_drive, 0);
        chk("R2 back enabled", port_state, 2'b01);
    endtask

    task automatic t_sw_resume;
        wr(M_EN | M_SUSP);
        ev(1);
        chk("R3 resuspended", port_state, 2'b10);
        wr(M_EN | M_SUSP | M_FPR);
        chk("R6 fpr set", rd_data[6], 1);
        chk("R6 no pulse", chg_pulse, 0);
        idle(1);
        chk("R6 no pulse later", chg_pulse, 0);
        wr(M_EN);
        ev(2);
        chk("R8 sw resume done", rd_data[6], 0);
        ev(0);
        chk("R5 jk when enabled ignored", rd_data[6], 0);
        chk("R5 jk no pulse", chg_pulse, 0);
    endtask

    task automatic t_disabled_susp;
        wr(8'h00);
        chk("R2 disabled", port_state, 2'b00);
        wr(M_SUSP);
        ev(1);
        chk("R3 disabled request dropped", rd_data[7], 0);
        wr(M_EN);
        ev(1);
        chk("R3 no stale request", rd_data[7], 0);
    endtask

    task automatic t_overcurrent;
        oc_in = 1'b1;
        @(negedge clk);
        chk("R9 oca follows", rd_data[2], 1);
        chk("R9 occ set", rd_data[3], 1);
        wr(M_EN | M_OCC);
        chk("R10 occ cleared", rd_data[3], 0);
        chk("R9 oca stays", rd_data[2], 1);
        oc_in = 1'b0;
        @(negedge clk);
        chk("R9 oca falls", rd_data[2], 0);
        chk("R9 occ on fall", rd_data[3], 1);
        wr(M_EN | M_OCC);
        chk("R10 occ cleared again", rd_data[3], 0);
        oc_in = 1'b1;
        wr(M_EN | M_OCC);
        chk("R10 occ set wins", rd_data[3], 1);
        wr(M_EN | M_OCC);
        chk("R10 occ clear after", rd_data[3], 0);
        oc_in = 1'b0;
        @(negedge clk);
        wr(M_EN | M_OCC);
    endtask

    task automatic t_port_error;
        ev(3);
        chk("R11 error disables", port_state, 2'b00);
        chk("R11 pec set", rd_data[1], 1);
        wr(M_PEC);
        chk("R10 pec cleared", rd_data[1], 0);
        ev(3);
        chk("R11 no pec when disabled", rd_data[1], 0);
        wr(M_EN);
        chk("R11 no pec on re-enable", rd_data[1], 0);
        eof_err = 1'b1;
        wr(M_EN | M_PEC);
        eof_err = 1'b0;
        chk("R10 pec set wins", rd_data[1], 1);
        chk("R11 error beats enable", rd_data[0], 0);
        wr(M_PEC);
    endtask

    task automatic t_disable_clears;
        wr(M_EN);
        wr(M_EN | M_SUSP);
        ev(1);
        ev(0);
        chk("R12 setup resume", rd_data[7:6], 2'b11);
        ev(3);
        chk("R12 susp fpr cleared", rd_data[7:6], 2'b00);
        chk("R12 rsm off", rsm_drive, 0);
        wr(M_EN | M_PEC);
        wr(M_EN | M_SUSP);
        wr(8'h00);
        ev(1);
        chk("R12 request dropped", rd_data[7], 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable;
        t_suspend;
        t_line_resume;
        t_sw_resume;
        t_disabled_susp;
        t_overcurrent;
        t_port_error;
        t_disable_clears;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule